// File: doc/BRIEF.md
# Physical Register Free List

This block hands out physical register indices to the rename stage of an out-of-order core. Each rename lane raises a request when its instruction needs a destination. In the same cycle, the lane gets back a grant flag and the index it was given. Unused indices are kept in a circular queue. Grants come from the head of the queue, and retiring instructions return the indices they displaced to the tail.

Each rename lane can also ask to save the current allocation head against a branch tag. When a branch is found to be mispredicted, a redirect names that tag. The head then moves back to the saved position, so every index handed out after the branch becomes free again. At reset the queue holds indices 1 to 63 in ascending order. Index 0 is reserved and never leaves or enters the queue.

Top module: `freelist_alloc`

## Requirements
- R1: After reset the queue holds indices 1 to 63 in ascending order, and all four lanes report a grant flag of 1 while no lane requests.
- R2: Lane k is granted when it requests and the free count is greater than the number of grants made to lanes 0..k-1 in the same cycle. Granted lanes receive consecutive queue entries in lane order, starting at the head.
- R3: A lane that is not granted reads index 0 on its index output, and the head does not move for it.
- R4: When fewer entries are free than lanes request, only the lowest requesting lanes are granted, up to the free count. With nothing free, no lane is granted.
- R5: Freed indices are appended at the tail in commit-lane order. They can be allocated from the next cycle onward, not in the cycle they are freed.
- R6: A free request carrying index 0 is ignored, and index 0 is never granted.
- R7: A checkpoint request on lane k stores, under its 3-bit tag, the head position after the grants of lanes 0..k. When several lanes use the same tag in one cycle, the highest lane's value is kept.
- R8: A redirect sets the head, at the next edge, to the value saved under the redirect tag. Allocations and checkpoint requests made in the redirect cycle are discarded.
- R9: Free requests made in a redirect cycle still append to the tail.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| allocReq | input | 4 | Per rename lane: needs a destination |
| canAlloc | output | 4 | Per rename lane: grant possible this cycle |
| allocIdx | output | 4x6 | Per rename lane: granted index, 0 when not granted |
| freeReq | input | 4 | Per commit lane: return an index |
| freeIdx | input | 4x6 | Per commit lane: displaced index being returned |
| cpValid | input | 4 | Per rename lane: save head under the tag |
| cpTag | input | 4x3 | Per rename lane: branch tag |
| redirectValid | input | 1 | Roll the head back |
| redirectTag | input | 3 | Tag whose saved head is restored |

## Verification
A redirect can arrive in the same cycle as new grants, checkpoint saves and frees. The bench drives all of these together. It judges the result by the indices handed out in the following cycles. These indices show whether the grants were undone, whether the checkpoint saved in that cycle was dropped, and whether the returned indices stayed in the queue. The queue is also drained completely, so that a free and a request can fall in the same cycle while the count is zero.

// File: rtl/fl_pkg.sv
package fl_pkg;
  localparam int PREGS    = 64;
  localparam int RN_LANES = 4;
  localparam int CM_LANES = 4;
  localparam int TAG_NUM  = 8;

  localparam int IDXW  = $clog2(PREGS);
  localparam int PTRW  = IDXW + 1;
  localparam int TAGW  = $clog2(TAG_NUM);
  localparam int RCNTW = $clog2(RN_LANES + 1);
  localparam int CCNTW = $clog2(CM_LANES + 1);

  typedef struct packed {
    logic [RCNTW-1:0]    allocCnt;
    logic [CCNTW-1:0]    freeCnt;
    logic [CM_LANES-1:0] freeMask;
    logic [RN_LANES-1:0] cpWrite;
    logic                restore;
  } flStrobe_t;
endpackage

// File: rtl/fl_ctrl.sv
module fl_ctrl
  import fl_pkg::*;
(
  input  logic                            clk,
  input  logic                            rstN,
  input  logic [RN_LANES-1:0]             allocReq,
  input  logic [RN_LANES-1:0]             cpValid,
  input  logic [CM_LANES-1:0]             freeReq,
  input  logic [CM_LANES-1:0][IDXW-1:0]   freeIdx,
  input  logic                            redirectValid,
  input  logic [PTRW-1:0]                 freeCount,
  output logic [RN_LANES-1:0]             canAlloc,
  output logic [RN_LANES-1:0]             grant,
  output logic [RN_LANES-1:0][RCNTW-1:0]  allocOfs,
  output logic [RN_LANES-1:0][RCNTW-1:0]  cpOfs,
  output logic [CM_LANES-1:0][CCNTW-1:0]  freeOfs,
  output flStrobe_t                       strobe
);
  logic [RCNTW-1:0] aAcc;
  logic [CCNTW-1:0] fAcc;
  logic [CM_LANES-1:0] freeMask;

  always_comb begin
    aAcc = '0;
    for (int k = 0; k < RN_LANES; k++) begin
      allocOfs[k] = aAcc;
      canAlloc[k] = freeCount > PTRW'(aAcc);
      grant[k]    = allocReq[k] && canAlloc[k];
      aAcc        = aAcc + RCNTW'(grant[k]);
      cpOfs[k]    = aAcc;
    end
  end

  always_comb begin
    fAcc = '0;
    for (int c = 0; c < CM_LANES; c++) begin
      freeOfs[c]  = fAcc;
      freeMask[c] = freeReq[c] && (freeIdx[c] != '0);
      fAcc        = fAcc + CCNTW'(freeMask[c]);
    end
  end

  always_comb begin
    strobe.allocCnt = aAcc;
    strobe.freeCnt  = fAcc;
    strobe.freeMask = freeMask;
    strobe.cpWrite  = redirectValid ? '0 : cpValid;
    strobe.restore  = redirectValid;
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rstN)
    PTRW'(strobe.allocCnt) <= freeCount); // R4

  for (genvar k = 1; k < RN_LANES; k++) begin : g_prefix
    AST_GRANT_PREFIX: assert property (@(posedge clk) disable iff (!rstN)
      grant[k] && allocReq[k-1] |-> grant[k-1]); // R4
  end
endmodule

// File: rtl/fl_queue.sv
module fl_queue
  import fl_pkg::*;
(
  input  logic                            clk,
  input  logic                            rstN,
  input  flStrobe_t                       strobe,
  input  logic [RN_LANES-1:0]             grant,
  input  logic [RN_LANES-1:0][RCNTW-1:0]  allocOfs,
  input  logic [RN_LANES-1:0][RCNTW-1:0]  cpOfs,
  input  logic [CM_LANES-1:0][CCNTW-1:0]  freeOfs,
  input  logic [CM_LANES-1:0][IDXW-1:0]   freeIdx,
  input  logic [RN_LANES-1:0][TAGW-1:0]   cpTag,
  input  logic [TAGW-1:0]                 redirectTag,
  output logic [RN_LANES-1:0][IDXW-1:0]   allocIdx,
  output logic [PTRW-1:0]                 freeCount
);
  logic [IDXW-1:0] slots [PREGS];
  logic [PTRW-1:0] cpSlot [TAG_NUM];
  logic [PTRW-1:0] headPtr, tailPtr, ckptSel;
  logic [RN_LANES-1:0][PTRW-1:0] rdPtr;
  logic [CM_LANES-1:0][PTRW-1:0] wrPtr;

  assign freeCount = tailPtr - headPtr;
  assign ckptSel   = cpSlot[redirectTag];

  always_comb begin
    for (int k = 0; k < RN_LANES; k++) begin
      rdPtr[k]    = headPtr + PTRW'(allocOfs[k]);
      allocIdx[k] = grant[k] ? slots[rdPtr[k][IDXW-1:0]] : '0;
    end
    for (int c = 0; c < CM_LANES; c++) begin
      wrPtr[c] = tailPtr + PTRW'(freeOfs[c]);
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < PREGS; i++) begin
        slots[i] <= (i < PREGS - 1) ? IDXW'(i + 1) : '0;
      end
      for (int t = 0; t < TAG_NUM; t++) begin
        cpSlot[t] <= '0;
      end
      headPtr <= '0;
      tailPtr <= PTRW'(PREGS - 1);
    end else begin
      for (int c = 0; c < CM_LANES; c++) begin
        if (strobe.freeMask[c]) slots[wrPtr[c][IDXW-1:0]] <= freeIdx[c];
      end
      for (int k = 0; k < RN_LANES; k++) begin
        if (strobe.cpWrite[k]) cpSlot[cpTag[k]] <= headPtr + PTRW'(cpOfs[k]);
      end
      tailPtr <= tailPtr + PTRW'(strobe.freeCnt);
      headPtr <= strobe.restore ? ckptSel : headPtr + PTRW'(strobe.allocCnt);
    end
  end

  AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (!rstN)
    freeCount <= PTRW'(PREGS - 1)); // R5

  AST_REDIRECT_RESTORE: assert property (@(posedge clk) disable iff (!rstN)
    strobe.restore |=> headPtr == $past(ckptSel)); // R8

  for (genvar k = 0; k < RN_LANES; k++) begin : g_zero
    AST_NO_ZERO_ALLOC: assert property (@(posedge clk) disable iff (!rstN)
      grant[k] |-> allocIdx[k] != '0); // R6
  end
endmodule

// File: rtl/freelist_alloc.sv
module freelist_alloc
  import fl_pkg::*;
(
  input  logic                           clk,
  input  logic                           rstN,
  input  logic [RN_LANES-1:0]            allocReq,
  output logic [RN_LANES-1:0]            canAlloc,
  output logic [RN_LANES-1:0][IDXW-1:0]  allocIdx,
  input  logic [CM_LANES-1:0]            freeReq,
  input  logic [CM_LANES-1:0][IDXW-1:0]  freeIdx,
  input  logic [RN_LANES-1:0]            cpValid,
  input  logic [RN_LANES-1:0][TAGW-1:0]  cpTag,
  input  logic                           redirectValid,
  input  logic [TAGW-1:0]                redirectTag
);
  flStrobe_t strobe;
  logic [RN_LANES-1:0] grant;
  logic [RN_LANES-1:0][RCNTW-1:0] allocOfs, cpOfs;
  logic [CM_LANES-1:0][CCNTW-1:0] freeOfs;
  logic [PTRW-1:0] freeCount;

  fl_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .allocReq(allocReq), .cpValid(cpValid),
    .freeReq(freeReq), .freeIdx(freeIdx), .redirectValid(redirectValid),
    .freeCount(freeCount), .canAlloc(canAlloc), .grant(grant),
    .allocOfs(allocOfs), .cpOfs(cpOfs), .freeOfs(freeOfs), .strobe(strobe)
  );

  fl_queue u_queue (
    .clk(clk), .rstN(rstN), .strobe(strobe), .grant(grant),
    .allocOfs(allocOfs), .cpOfs(cpOfs), .freeOfs(freeOfs), .freeIdx(freeIdx),
    .cpTag(cpTag), .redirectTag(redirectTag), .allocIdx(allocIdx),
    .freeCount(freeCount)
  );
endmodule

// File: tb/sim_freelist_alloc.sv
module sim_freelist_alloc;
  logic clk = 1'b0;
  logic rstN;
  logic [3:0] allocReq, canAlloc, freeReq, cpValid;
  logic [3:0][5:0] allocIdx, freeIdx;
  logic [3:0][2:0] cpTag;
  logic redirectValid;
  logic [2:0] redirectTag;
  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  freelist_alloc u0 (
    .clk(clk), .rstN(rstN), .allocReq(allocReq), .canAlloc(canAlloc),
    .allocIdx(allocIdx), .freeReq(freeReq), .freeIdx(freeIdx),
    .cpValid(cpValid), .cpTag(cpTag), .redirectValid(redirectValid),
    .redirectTag(redirectTag)
  );

  task automatic idle();
    allocReq = '0; freeReq = '0; freeIdx = '0; cpValid = '0; cpTag = '0;
    redirectValid = 1'b0; redirectTag = '0;
  endtask

  task automatic chk(string req, int k, bit expCan, int expIdx);
    checks++;
    if (canAlloc[k] !== expCan || int'(allocIdx[k]) != expIdx) begin
      fails++;
      $display("FAIL %s lane%0d: can=%0b idx=%0d, expected can=%0b idx=%0d",
               req, k, canAlloc[k], allocIdx[k], expCan, expIdx);
    end
  endtask

  task automatic advance();
    @(negedge clk);
    idle();
  endtask

  task automatic t_reset();
    #1; for (int k = 0; k < 4; k++) chk("R1", k, 1'b1, 0);
    allocReq = 4'b1111; #1;
    for (int k = 0; k < 4; k++) chk("R1", k, 1'b1, k + 1);
    allocReq = 4'b0000;
    advance();
  endtask

  task automatic t_partial_lanes();
    allocReq = 4'b0011; cpValid = 4'b0010; cpTag[1] = 3'd2; #1;
    chk("R2", 0, 1'b1, 1); chk("R2", 1, 1'b1, 2);
    chk("R3", 2, 1'b1, 0); chk("R3", 3, 1'b1, 0);
    advance();
    allocReq = 4'b1111; cpValid = 4'b0101; cpTag[0] = 3'd3; cpTag[2] = 3'd3; #1;
    for (int k = 0; k < 4; k++) chk("R2", k, 1'b1, k + 3);
    advance();
  endtask

  task automatic t_redirect();
    allocReq = 4'b1111; redirectValid = 1'b1; redirectTag = 3'd3;
    cpValid = 4'b0001; cpTag[0] = 3'd2; #1;
    chk("R8", 0, 1'b1, 7);
    advance();
    allocReq = 4'b0001; #1;
    chk("R7", 0, 1'b1, 6);
    advance();
    redirectValid = 1'b1; redirectTag = 3'd2;
    advance();
    allocReq = 4'b0001; #1;
    chk("R8", 0, 1'b1, 3);
    advance();
  endtask

  task automatic t_exhaust_and_free();
    for (int i = 0; i < 15; i++) begin
      allocReq = 4'b1111; #1;
      for (int k = 0; k < 4; k++) chk("R2", k, 1'b1, 4 + 4 * i + k);
      advance();
    end
    allocReq = 4'b1111; #1;
    for (int k = 0; k < 4; k++) chk("R4", k, 1'b0, 0);
    advance();
    freeReq = 4'b1011; freeIdx[0] = 6'd40; freeIdx[1] = 6'd0;
    freeIdx[2] = 6'd50; freeIdx[3] = 6'd41; allocReq = 4'b0001; #1;
    chk("R5", 0, 1'b0, 0);
    advance();
    allocReq = 4'b1111; #1;
    chk("R5", 0, 1'b1, 40); chk("R6", 1, 1'b1, 41);
    chk("R4", 2, 1'b0, 0); chk("R4", 3, 1'b0, 0);
    advance();
  endtask

  task automatic t_redirect_with_free();
    cpValid = 4'b0001; cpTag[0] = 3'd5; freeReq = 4'b0001; freeIdx[0] = 6'd20;
    advance();
    allocReq = 4'b0001; freeReq = 4'b0001; freeIdx[0] = 6'd21;
    redirectValid = 1'b1; redirectTag = 3'd5; #1;
    chk("R8", 0, 1'b1, 20);
    advance();
    allocReq = 4'b0111; #1;
    chk("R8", 0, 1'b1, 20); chk("R9", 1, 1'b1, 21); chk("R9", 2, 1'b0, 0);
    advance();
  endtask

  initial begin
    idle();
    rstN = 1'b0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    t_reset();
    t_partial_lanes();
    t_redirect();
    t_exhaust_and_free();
    t_redirect_with_free();
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #100000;
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule